// File: doc/BRIEF.md
# Parity-Protected Asynchronous SRAM Controller

This block sits between an on-chip requester and an external 128K x 9 asynchronous static RAM. The requester issues one access at a time over a valid/ready handshake carrying a 17-bit word address and, for writes, one data byte. The controller adds a ninth bit that makes each stored word's parity even. On reads it returns the byte together with a flag that is set when the nine bits read back have odd parity.

The memory has two chip selects of opposite sense: an active-low select and an active-high select. It also has an active-low output enable and an active-low write enable. The data path to the pads is split into a drive value, a drive enable and a receive value. Every strobe phase is counted in clock cycles: the length of each phase is the nanosecond limit of the chosen speed grade divided by the clock period and rounded up. Between accesses the device is left deselected, which is its low-current standby state.

A retention input parks the device deselected, so that the supply may be lowered. When that input is released, the controller waits out a recovery period before it accepts another request.

Top module: `sram_par_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the controller holds mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0. It also shows req_ready=1 unless ret_en is high.
- R2: A write stores the 9-bit word {^data, data} at the requested address. Bit 8 is the XOR of the 8 data bits, so every stored word has an even number of ones.
- R3: A write holds mem_we_n low with both selects active and mem_oe_n high for WP cycles. WP = max(ceil(tAW/T), ceil(tWP/T), ceil(tDW/T), ceil(tWC/T)-1, 1), where T is CLK_NS. The grade table (GRADE 0/1/2) gives tAW=50/60/70, tWP=40/50/60, tDW=25/30/40 and tWC=55/70/100 ns. One further cycle follows with mem_we_n high while the address and the driven data stay unchanged. The data driver is then released.
- R4: A read holds both selects active and mem_oe_n low for RD = ceil(tRC/T) cycles, with tRC=55/70/100 ns. The memory word is sampled at the end of that window. rsp_valid then pulses for one cycle with rsp_rdata = bits 7:0 of the word.
- R5: rsp_perr is 1 exactly when the 9-bit word read has an odd number of ones. rsp_rdata and rsp_perr keep their values until the next read completes, and writes do not change them.
- R6: After a read, the device is deselected and req_ready stays low for HZ = ceil(tOHZ/T) cycles, with tOHZ=25/25/35 ns. This gives the memory time to release the bus before the next access.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0.
- R8: When ret_en is high at an idle cycle, ret_hold becomes 1 and the device is held deselected (mem_ce1_n=1, mem_ce2=0). req_ready stays 0, and requests are stalled without any strobe reaching the memory.
- R9: After ret_en falls, req_ready stays 0 for RCV = ceil(RECOV_NS/T) cycles, and stored data is still readable afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata | output | 8 | Last read byte |
| rsp_perr | output | 1 | Parity error of last read |
| ret_en | input | 1 | Request retention parking |
| ret_hold | output | 1 | Device parked for retention |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 9 | Data to the pads |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | 9 | Data from the pads |

## Verification
The bench counts the cycles of each strobe window. A controller that rounded down or dropped the clamps would show a write pulse or read window one cycle short, and one that skipped the bus turnaround would raise ready early after a read. It writes at the lowest and highest addresses and then corrupts a stored parity bit, so a design that computed odd parity or checked only the data bits would miss the error flag. It also checks that the flag survives a later write. It issues requests during retention and counts the recovery cycles, which catches a controller that strobes a parked device or resumes before recovery ends.

// File: rtl/sram_par_ctrl.sv
module sram_par_ctrl #(
  parameter int CLK_NS   = 10,
  parameter int GRADE    = 0,
  parameter int RECOV_NS = 5_000_000,
  parameter int AW       = 17,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_perr,
  input  logic          ret_en,
  output logic          ret_hold,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW:0]   mem_dq_i
);

  function automatic int cdiv(input int ns);
    int r;
    r = (ns + CLK_NS - 1) / CLK_NS;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_RC = (GRADE == 0) ? 55 : (GRADE == 1) ? 70 : 100;
  localparam int T_AW = (GRADE == 0) ? 50 : (GRADE == 1) ? 60 : 70;
  localparam int T_WP = (GRADE == 0) ? 40 : (GRADE == 1) ? 50 : 60;
  localparam int T_DW = (GRADE == 0) ? 25 : (GRADE == 1) ? 30 : 40;
  localparam int T_HZ = (GRADE == 2) ? 35 : 25;
  localparam int RD_C  = cdiv(T_RC);
  localparam int WP_C  = imax(imax(cdiv(T_AW), cdiv(T_WP)), imax(cdiv(T_DW), imax(cdiv(T_RC) - 1, 1)));
  localparam int HZ_C  = cdiv(T_HZ);
  localparam int RCV_C = cdiv(RECOV_NS);
  localparam int CW = 32;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WEND, S_RD, S_RDHZ, S_RET, S_RCV} state_t;
  state_t state;
  logic [CW-1:0] cnt;
  wire last = (cnt == '0);

  assign req_ready = (state == S_IDLE) && !ret_en;
  assign ret_hold  = (state == S_RET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      mem_addr <= '0;
      mem_ce1_n <= 1'b1;
      mem_ce2 <= 1'b0;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_dq_o <= '0;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_perr <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ret_en) state <= S_RET;
          else if (req_valid) begin
            mem_addr <= req_addr;
            mem_ce1_n <= 1'b0;
            mem_ce2 <= 1'b1;
            if (req_we) begin
              mem_we_n <= 1'b0;
              mem_dq_o <= {^req_wdata, req_wdata};
              mem_dq_oe <= 1'b1;
              cnt <= CW'(WP_C - 1);
              state <= S_WR;
            end else begin
              mem_oe_n <= 1'b0;
              cnt <= CW'(RD_C - 1);
              state <= S_RD;
            end
          end
        end
        S_WR: begin
          if (last) begin
            mem_we_n <= 1'b1;
            state <= S_WEND;
          end else cnt <= cnt - 1'b1;
        end
        S_WEND: begin
          mem_ce1_n <= 1'b1;
          mem_ce2 <= 1'b0;
          mem_dq_oe <= 1'b0;
          state <= S_IDLE;
        end
        S_RD: begin
          if (last) begin
            rsp_rdata <= mem_dq_i[DW-1:0];
            rsp_perr <= ^mem_dq_i;
            rsp_valid <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_ce1_n <= 1'b1;
            mem_ce2 <= 1'b0;
            cnt <= CW'(HZ_C - 1);
            state <= S_RDHZ;
          end else cnt <= cnt - 1'b1;
        end
        S_RDHZ: begin
          if (last) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_RET: begin
          if (!ret_en) begin
            cnt <= CW'(RCV_C - 1);
            state <= S_RCV;
          end
        end
        S_RCV: begin
          if (last) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] wlen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wlen <= '0;
    else wlen <= mem_we_n ? '0 : wlen + 1'b1;
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));
  // R2
  even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (^mem_dq_o == 1'b0));
  // R3
  we_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n && mem_dq_oe));
  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlen == CW'(WP_C)));
  // R3
  we_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && mem_dq_oe));
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  // R8
  ret_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_hold |-> (mem_ce1_n && !mem_ce2 && !req_ready));

endmodule

// File: tb/sram_par_ctrl_tb_top.sv
module sram_par_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_RD = 6;
  localparam int EXP_WP = 5;
  localparam int EXP_HZ = 3;
  localparam int EXP_RCV = 200;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, ret_en = 0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_perr, ret_hold;
  logic [7:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [8:0] mem_dq_o, mem_dq_i;

  int checks = 0, errors = 0, contention = 0;
  logic [8:0] model [int];
  logic [8:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_par_ctrl #(.CLK_NS(CLK_PERIOD), .GRADE(0), .RECOV_NS(2000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
    .ret_en(ret_en), .ret_hold(ret_hold), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i));

  always @* begin
    if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
      mem_dq_i = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 9'h000;
    else
      mem_dq_i = 9'h1FF;
  end

  always @(posedge mem_we_n)
    if (!mem_ce1_n && mem_ce2 && mem_dq_oe) model[int'(mem_addr)] = mem_dq_o;

  always @(negedge clk) if (rst_n && mem_dq_oe && !mem_oe_n) contention++;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk("R4 unexpected response", 0, 1, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk("R4/R5 read data and parity flag", {rsp_perr, rsp_rdata} == e,
            int'({rsp_perr, rsp_rdata}), int'(e));
      end
    end
  end

  task automatic handshake(input bit we, input logic [16:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int n = 0;
    handshake(1, a, d);
    while (!mem_we_n) begin n++; @(negedge clk); end
    chk("R3 write pulse cycles", n == EXP_WP, n, EXP_WP);
    chk("R3 address and data held after WE rises",
        mem_dq_oe && mem_addr == a && mem_dq_o == {^d, d}, int'(mem_dq_o), int'({^d, d}));
    @(negedge clk);
    chk("R1 standby after write", mem_ce1_n && !mem_ce2 && !mem_dq_oe && req_ready,
        int'({mem_ce1_n, mem_ce2, mem_dq_oe, req_ready}), 'b1001);
    chk("R2 stored word with even parity",
        model.exists(int'(a)) && model[int'(a)] == {^d, d},
        model.exists(int'(a)) ? int'(model[int'(a)]) : -1, int'({^d, d}));
  endtask

  task automatic do_read(input logic [16:0] a, input logic [8:0] exp);
    int n = 0, m = 0;
    expq.push_back(exp);
    handshake(0, a, 8'h00);
    while (!mem_oe_n) begin n++; @(negedge clk); end
    chk("R4 read window cycles", n == EXP_RD, n, EXP_RD);
    while (!req_ready) begin m++; @(negedge clk); end
    chk("R6 turnaround cycles after read", m == EXP_HZ, m, EXP_HZ);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", req_ready && mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe,
        int'({req_ready, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}), 'b110110);

    do_write(17'h00000, 8'h00);
    do_write(17'h1FFFF, 8'hA5);
    do_write(17'h12345, 8'hFF);
    do_write(17'h00005, 8'h01);
    do_read(17'h00000, 9'h000);
    do_read(17'h1FFFF, {1'b0, 8'hA5});
    do_read(17'h12345, {1'b0, 8'hFF});

    model[5] = model[5] ^ 9'h100;
    do_read(17'h00005, {1'b1, 8'h01});
    do_write(17'h00009, 8'h3C);
    chk("R5 flag and data held across write", rsp_perr && rsp_rdata == 8'h01,
        int'({rsp_perr, rsp_rdata}), 'h101);
    do_read(17'h00009, {1'b0, 8'h3C});

    ret_en = 1;
    @(negedge clk);
    chk("R8 retention parked", ret_hold && !req_ready && mem_ce1_n && !mem_ce2,
        int'({ret_hold, req_ready, mem_ce1_n, mem_ce2}), 'b1010);
    req_valid = 1; req_we = 0; req_addr = 17'h12345;
    begin
      int strobes = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (!mem_ce1_n || mem_ce2 || !mem_oe_n || !mem_we_n || req_ready) strobes++;
      end
      chk("R8 request stalled during retention", strobes == 0, strobes, 0);
    end
    req_valid = 0;
    ret_en = 0;
    begin
      int n = 0;
      @(negedge clk);
      while (!req_ready) begin n++; @(negedge clk); end
      chk("R9 recovery cycles", n == EXP_RCV, n, EXP_RCV);
    end
    do_read(17'h12345, {1'b0, 8'hFF});

    repeat (4) @(negedge clk);
    chk("R4 all responses received", expq.size() == 0, expq.size(), 0);
    chk("R7 no driver while output enabled", contention == 0, contention, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule